// File: doc/BRIEF.md
# Programmable Microsecond Down-Counting Timer

This block is one programmable timer that counts down on a one-microsecond tick enable. It has two modes. In one-shot mode it raises an interrupt once and then stops. In periodic mode it raises an interrupt every N ticks until software stops it. Software uses a small memory-mapped register bus with two words. The arm word, at offset 0x0, holds the enable bit, the mode bit and the programmed count, all packed into a single write. The status word, at offset 0x4, acknowledges the interrupt when written. When read, it shows the pending flag and the count that remains.

The count field is loaded as N−1. A write of N−1 therefore gives an expiry on the N-th tick after the write. A periodic timer written with 9999 expires every 10 ms. The tick input is a single-cycle enable that comes from elsewhere. Between ticks the timer holds its state. The interrupt output is a level that stays high until it is acknowledged. The bus carries control words, not a data stream. Accesses complete in the cycle they are presented, reads have no side effects, and there is no back-pressure.

Top module: `tick_timer`

## Requirements
- R1: After reset, the interrupt is low and both words read as zero.
- R2: Writing the arm word (offset 0x0) loads three fields: enable from bit 31, periodic mode from bit 30, and the programmed count from bits 28:0. Bit 29 is ignored. The remaining count restarts from the written value. Reading the arm word returns enable in bit 31, mode in bit 30 and the programmed count in bits 28:0.
- R3: While the timer is enabled, each tick with a nonzero remaining count lowers that count by one. While the timer is disabled, ticks change nothing.
- R4: A tick that arrives while the remaining count is zero and the timer is enabled is an expiry. As a result, a programmed value of N−1 expires on the N-th tick after the write.
- R5: On a one-shot expiry the enable bit clears and the remaining count stays at zero. No further expiry follows without a new arm write.
- R6: On a periodic expiry the remaining count reloads from the programmed value on the same tick, so expiries repeat every N ticks.
- R7: Writing the status word (offset 0x4) with bit 30 set clears the pending interrupt. A write with bit 30 clear has no effect.
- R8: If an expiry and an acknowledge fall in the same cycle, the interrupt stays pending.
- R9: Writing zero to the arm word stops the timer. The pending flag is unaffected.
- R10: If an arm write and a tick fall in the same cycle, the write wins and the tick is dropped.
- R11: Reading the status word returns the pending flag in bit 30 and the remaining count in bits 28:0. All other bits read zero. Any other offset reads zero, and nothing is read while the bus select is low.
- R12: The interrupt is an active-high level that is set on expiry and held until it is acknowledged.
- R13: The largest count, 0x1FFFFFFF, is accepted and reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset (0x0 arm word, 0x4 status word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when not selected |
| tick | input | 1 | One-microsecond tick enable |
| irq | output | 1 | Active-high level interrupt |

## Verification
The bench aims its tests at the moments when two events collide.

- **Acknowledge and expiry in the same cycle.** The expiry must win. A design that gives the acknowledge priority drops an interrupt.
- **Arm write and tick in the same cycle.** A design that lets the tick through starts one tick short.
- **Off-by-one in the N−1 load.** Getting this wrong shifts every expiry by one tick.
- **Periodic reload.** A reload that goes through an extra zero cycle stretches each period to N+1.
- **One-shot behaviour after expiry.** A one-shot timer that keeps its enable set keeps firing.
- **Stopped timer.** A stopped timer that still takes ticks drifts its remaining count.

Long runs with sparse ticks and random accesses are compared cycle by cycle against a behavioural model. This exposes each of these errors as a mismatch on `irq` or on a read word.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // bit positions inside the arm and status words
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned MODE_BIT = 30;
  localparam int unsigned PEND_BIT = 30;
  localparam int unsigned ACK_BIT  = 30;

  // byte offsets of the two words
  localparam logic [7:0] ARM_OFS  = 8'h00;
  localparam logic [7:0] STAT_OFS = 8'h04;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ARM  = 2'd1,
    SEL_STAT = 2'd2
  } word_sel_e;
endpackage

// File: rtl/tick_timer_bus.sv
module tick_timer_bus
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              arm_wr,
  output logic              arm_en,
  output logic              arm_periodic,
  output logic [CNT_W-1:0]  arm_value,
  output logic              ack_wr,
  input  logic              run,
  input  logic              periodic,
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  count,
  input  logic              pend
);
  word_sel_e wsel;

  always_comb begin
    if (!bus_sel)
      wsel = SEL_NONE;
    else if (bus_addr == ADDR_W'(ARM_OFS))
      wsel = SEL_ARM;
    else if (bus_addr == ADDR_W'(STAT_OFS))
      wsel = SEL_STAT;
    else
      wsel = SEL_NONE;
  end

  assign arm_wr       = bus_we && (wsel == SEL_ARM);
  assign ack_wr       = bus_we && (wsel == SEL_STAT) && bus_wdata[ACK_BIT];
  assign arm_en       = bus_wdata[EN_BIT];
  assign arm_periodic = bus_wdata[MODE_BIT];
  assign arm_value    = bus_wdata[CNT_W-1:0];

  always_comb begin
    bus_rdata = '0;
    case (wsel)
      SEL_ARM: begin
        bus_rdata[EN_BIT]    = run;
        bus_rdata[MODE_BIT]  = periodic;
        bus_rdata[CNT_W-1:0] = reload;
      end
      SEL_STAT: begin
        bus_rdata[PEND_BIT]  = pend;
        bus_rdata[CNT_W-1:0] = count;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R11
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata == '0);
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm_wr,
  input  logic             arm_en,
  input  logic             arm_periodic,
  input  logic [CNT_W-1:0] arm_value,
  output logic             run,
  output logic             periodic,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;
  logic at_zero;

  assign step    = run && tick && !arm_wr;
  assign at_zero = (count == '0);
  assign expire  = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      periodic <= 1'b0;
      reload   <= '0;
      count    <= '0;
    end else if (arm_wr) begin
      run      <= arm_en;
      periodic <= arm_periodic;
      reload   <= arm_value;
      count    <= arm_value;
    end else if (step) begin
      if (at_zero) begin
        if (periodic) count <= reload;
        else          run   <= 1'b0;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  // R3
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !arm_wr && count != '0) |=> count == $past(count) - 1'b1);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !arm_wr) |=> $stable(count) && !run);
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !periodic) |=> !run && count == '0);
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> run && count == $past(reload));
  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> count == $past(arm_value) && run == $past(arm_en));
endmodule

// File: rtl/tick_timer_irq.sv
module tick_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack_wr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (expire) pend <= 1'b1;
    else if (ack_wr) pend <= 1'b0;
  end

  // R8
  expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
  // R12
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack_wr) |=> pend);
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !expire) |=> !pend);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  output logic              irq
);
  logic             arm_wr, arm_en, arm_periodic, ack_wr;
  logic [CNT_W-1:0] arm_value, reload, count;
  logic             run, periodic, expire, pend;

  tick_timer_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arm_wr(arm_wr), .arm_en(arm_en), .arm_periodic(arm_periodic),
    .arm_value(arm_value), .ack_wr(ack_wr),
    .run(run), .periodic(periodic), .reload(reload), .count(count), .pend(pend)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .arm_wr(arm_wr), .arm_en(arm_en), .arm_periodic(arm_periodic),
    .arm_value(arm_value),
    .run(run), .periodic(periodic), .reload(reload), .count(count),
    .expire(expire)
  );

  tick_timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack_wr(ack_wr), .pend(pend)
  );

  assign irq = pend;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, tick = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit          m_en, m_per, m_pend;
  int unsigned m_rel, m_cnt;

  always #4 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .irq(irq)
  );

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    if (bus_sel && bus_addr == 8'h00) begin
      v[31] = m_en; v[30] = m_per; v[28:0] = m_rel[28:0];
    end else if (bus_sel && bus_addr == 8'h04) begin
      v[30] = m_pend; v[28:0] = m_cnt[28:0];
    end
    return v;
  endfunction

  task automatic compare(string tag);
    logic [31:0] er = exp_rdata();
    checks++;
    if (irq !== m_pend) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b t=%0t", tag, irq, m_pend, $time);
    end
    checks++;
    if (bus_rdata !== er) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, bus_rdata, er, $time);
    end
  endtask

  // one clock: drive inputs, step model with them, compare after the edge
  task automatic cyc(bit sel, bit we, logic [7:0] a, logic [31:0] wd, bit tk, string tag);
    bit arm, ack, ex;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; tick = tk;
    @(posedge clk);
    #1;
    arm = sel && we && a == 8'h00;
    ack = sel && we && a == 8'h04 && wd[30];
    ex = 1'b0;
    if (arm) begin
      m_en = wd[31]; m_per = wd[30]; m_rel = wd[28:0]; m_cnt = wd[28:0];
    end else if (m_en && tk) begin
      if (m_cnt == 0) begin
        ex = 1'b1;
        if (m_per) m_cnt = m_rel; else m_en = 1'b0;
      end else m_cnt = m_cnt - 1;
    end
    if (ex) m_pend = 1'b1; else if (ack) m_pend = 1'b0;
    // keep a read of the status word on the bus so the count is observed
    bus_we = 1'b0; bus_sel = 1'b1; bus_addr = (a == 8'h00 || a == 8'h04) ? a : 8'h04;
    if (!sel) bus_addr = 8'h04;
    #1;
    compare(tag);
    bus_addr = a; bus_sel = sel;
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic arm_w(logic [31:0] v, bit tk, string tag);
    cyc(1, 1, 8'h00, v, tk, tag);
  endtask
  task automatic ack_w(logic [31:0] v, bit tk, string tag);
    cyc(1, 1, 8'h04, v, tk, tag);
  endtask
  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 8'h04, 32'h0, 1, tag);
  endtask
  task automatic idles(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'h0, 0, tag);
  endtask

  task automatic expect_irq(bit e, string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_en = 0; m_per = 0; m_pend = 0; m_rel = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_sel = 1; bus_addr = 8'h00; #1; compare("R1");
    bus_addr = 8'h04; #1; compare("R1");
    bus_sel = 0;
    @(negedge clk); rst_n = 1'b1;
    idles(2, "R1");

    // R3 ticks while disabled do nothing
    ticks(4, "R3");

    // R2/R4/R5 one-shot with N=5: expiry on fifth tick
    arm_w(32'h8000_0004, 0, "R2");
    cyc(1, 0, 8'h00, 0, 0, "R2");
    ticks(4, "R4");
    expect_irq(0, "R4");
    ticks(1, "R4");
    expect_irq(1, "R4");
    ticks(6, "R5");
    expect_irq(1, "R12");
    ack_w(32'h0000_0000, 0, "R7");
    expect_irq(1, "R7");
    ack_w(32'h4000_0000, 0, "R7");
    expect_irq(0, "R7");
    ticks(3, "R5");

    // R6 periodic N=3, sparse ticks
    arm_w(32'hC000_0002, 0, "R6");
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 3; k++) begin
        cyc(0, 0, 0, 0, 0, "R6");
        ticks(1, "R6");
      end
      expect_irq(1, "R6");
      ack_w(32'h4000_0000, 0, "R6");
    end

    // R8 ack coinciding with expiry: count is at 2 now, tick twice then ack+tick
    ticks(2, "R8");
    ack_w(32'h4000_0000, 1, "R8");
    expect_irq(1, "R8");
    ack_w(32'h4000_0000, 0, "R8");

    // R10 arm write on a tick: write wins
    arm_w(32'h8000_0007, 1, "R10");
    ticks(2, "R10");

    // R9 write zero stops, pending untouched
    arm_w(32'hC000_0000, 0, "R9");
    ticks(1, "R9");
    arm_w(32'h0000_0000, 0, "R9");
    expect_irq(1, "R9");
    ticks(5, "R9");
    ack_w(32'hFFFF_FFFF, 0, "R7");

    // R13 maximum count; bit 29 ignored; R11 other offset reads zero
    arm_w(32'hBFFF_FFFF, 1, "R13");
    ticks(3, "R13");
    cyc(1, 0, 8'h08, 0, 1, "R11");
    cyc(1, 1, 8'h0C, 32'hFFFF_FFFF, 1, "R11");
    arm_w(32'h0000_0000, 0, "R13");

    // random soak against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 19);
      bit tk = ($urandom_range(0, 1) == 1);
      logic [31:0] v = {$urandom_range(0, 7), 29'd0} | 32'($urandom_range(0, 6));
      if (r == 0)      arm_w(v, tk, "R6");
      else if (r == 1) ack_w(32'($urandom_range(0, 1)) << 30, tk, "R8");
      else             cyc(1, 0, (r[0] ? 8'h00 : 8'h04), 0, tk, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule